// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is a purely combinational 32-bit shifter. It serves the operand path of a processor datapath. It takes a data word, a two-bit shift kind, an 8-bit shift amount, a flag that says whether the amount was encoded in the instruction itself, and the current carry flag. It returns the shifted word and the carry-out that the flag logic downstream would latch.

The amount can be zero, exactly the word width, or larger than the word width. Each of these cases has its own defined result and carry. An immediate amount of zero does not mean "no shift":

- For logical right and arithmetic right it means a shift by 32.
- For rotate right it means a single-bit rotate through the carry.
- For logical left it means a plain pass-through.

A register-supplied amount of zero always passes the word and the carry through untouched.

Top module: `barrel_shift_carry`

## Requirements
- R1: The shift kind input uses the encoding 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. A logical left shift by n, with n from 1 to 32, returns the word shifted left by n with zeros filled in. The carry-out is input bit 32−n, which is the last bit shifted out.
- R2: A logical left shift by more than 32 returns zero with a carry-out of 0.
- R3: A logical right shift by n, with n from 1 to 32, returns the word shifted right with zero fill, and the carry-out is input bit n−1. A logical right shift by more than 32 returns zero with a carry-out of 0.
- R4: An arithmetic right shift by n, with n from 1 to 31, fills from the left with copies of bit 31, and the carry-out is input bit n−1. An arithmetic right shift by 32 or more returns every bit equal to input bit 31, and the carry-out is input bit 31.
- R5: A rotate right by n, with n from 1 to 31, returns the rotated word, and the carry-out is input bit n−1. A rotate by 32 leaves the word unchanged, and the carry-out is bit 31. Amounts above 32 are taken modulo 32, and a nonzero multiple of 32 acts as a rotate by 32.
- R6: With a register-supplied amount of 0 (immediate flag low), every shift kind returns the input word unchanged and passes the incoming carry through.
- R7: An immediate logical left shift with amount 0 returns the input word and the incoming carry unchanged.
- R8: An immediate logical right or arithmetic right shift with amount 0 behaves exactly as the same shift by 32.
- R9: An immediate rotate right with amount 0 is a one-bit rotate through carry. The incoming carry enters bit 31, and input bit 0 becomes the carry-out.
- R10: With a nonzero amount, the immediate flag has no effect. The result and carry equal those for the same amount supplied from a register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shift_kind | input | 2 | Shift kind: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right |
| shift_amount | input | 8 | Shift amount |
| amount_is_imm | input | 1 | High when the amount came from the instruction's immediate field |
| value_in | input | 32 | Word to shift |
| carry_in | input | 1 | Current carry flag |
| value_out | output | 32 | Shifted word |
| carry_out | output | 1 | Carry produced by the shift |

## Verification
Six fixed words and a stream of pseudo-random words are applied under every kind, both amount sources, both carry values and every amount from 0 to 40, plus 64, 96 and 255.

The fixed words each expose a different failure:
- The single-top-bit word and 0x0000_4001 show whether the carry is taken from the correct end of the word.
- 0x7FFF_FFFF and 0xFFFF_0000 separate sign fill from zero fill.
- The asymmetric words 0x123F_ABCE and 0xA5F9_6342 reveal rotate distances that are off by one and a rotate-through-carry that is wired the wrong way.

Amounts 32, 33, 64 and 96 separate "exactly the width" from "beyond the width" and from the modulo folding of rotates. Amount 0 with each setting of the immediate flag separates R6 from R7, R8 and R9.

// File: rtl/shift_pkg.sv
package shift_pkg;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_kind_e;

    typedef enum logic [1:0] {
        OP_PASS  = 2'd0,
        OP_RRX   = 2'd1,
        OP_SHIFT = 2'd2,
        OP_CLEAR = 2'd3
    } shift_op_e;

    typedef struct packed {
        shift_op_e   op;
        shift_kind_e kind;
    } shift_ctrl_t;

    function automatic logic left_kind(input shift_kind_e k);
        return k == SH_LSL;
    endfunction

endpackage

// File: rtl/shift_amount_decode.sv
module shift_amount_decode
    import shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    localparam int LOG_W = $clog2(DATA_W),
    localparam int CNT_W = LOG_W + 1
) (
    input  shift_kind_e       kind,
    input  logic [AMT_W-1:0]  amount,
    input  logic              is_imm,
    output shift_ctrl_t       ctrl,
    output logic [CNT_W-1:0]  count
);
    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

    logic             amt_zero;
    logic             beyond;
    logic [LOG_W-1:0] low_bits;
    logic [CNT_W-1:0] rot_count;

    assign amt_zero  = (amount == '0);
    assign beyond    = (amount > FULL_AMT);
    assign low_bits  = amount[LOG_W-1:0];
    assign rot_count = (low_bits == '0) ? FULL_CNT : {1'b0, low_bits};

    always_comb begin
        ctrl.kind = kind;
        ctrl.op   = OP_SHIFT;
        count     = amount[CNT_W-1:0];
        if (amt_zero) begin
            if (!is_imm) begin
                ctrl.op = OP_PASS;
            end else begin
                unique case (kind)
                    SH_LSL:         ctrl.op = OP_PASS;
                    SH_LSR, SH_ASR: count   = FULL_CNT;
                    SH_ROR:         ctrl.op = OP_RRX;
                    default:        ctrl.op = OP_PASS;
                endcase
            end
        end else begin
            unique case (kind)
                SH_LSL, SH_LSR: if (beyond) ctrl.op = OP_CLEAR;
                SH_ASR:         if (beyond) count = FULL_CNT;
                SH_ROR:         count = rot_count;
                default:        ctrl.op = OP_PASS;
            endcase
        end
    end

endmodule

// File: rtl/shift_log_stages.sv
module shift_log_stages #(
    parameter int VEC_W = 65,
    parameter int CNT_W = 6
) (
    input  logic [VEC_W-1:0] din,
    input  logic [CNT_W-1:0] count,
    output logic [VEC_W-1:0] dout
);
    logic [VEC_W-1:0] stage [0:CNT_W];

    assign stage[0] = din;

    generate
        for (genvar i = 0; i < CNT_W; i++) begin : g_stage
            assign stage[i+1] = count[i] ? (stage[i] >> (2 ** i)) : stage[i];
        end
    endgenerate

    assign dout = stage[CNT_W];

endmodule

// File: rtl/bit_reverse.sv
module bit_reverse #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign dout[i] = din[W-1-i];
        end
    endgenerate
endmodule

// File: rtl/barrel_shift_carry.sv
module barrel_shift_carry
    import shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [1:0]        shift_kind,
    input  logic [AMT_W-1:0]  shift_amount,
    input  logic              amount_is_imm,
    input  logic [DATA_W-1:0] value_in,
    input  logic              carry_in,
    output logic [DATA_W-1:0] value_out,
    output logic              carry_out
);
    localparam int CNT_W = $clog2(DATA_W) + 1;
    localparam int VEC_W = 2 * DATA_W + 1;

    shift_kind_e      kind;
    shift_ctrl_t      ctrl;
    logic [CNT_W-1:0] count;
    logic [DATA_W-1:0] rev_in;
    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] ext;
    logic [VEC_W-1:0]  wide_in;
    logic [VEC_W-1:0]  wide_out;
    logic [DATA_W-1:0] body;
    logic [DATA_W-1:0] rev_body;
    logic [DATA_W-1:0] core_value;
    logic              core_carry;

    assign kind = shift_kind_e'(shift_kind);

    shift_amount_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) i_decode (
        .kind   (kind),
        .amount (shift_amount),
        .is_imm (amount_is_imm),
        .ctrl   (ctrl),
        .count  (count)
    );

    bit_reverse #(.W(DATA_W)) i_rev_in (
        .din  (value_in),
        .dout (rev_in)
    );

    // Left shifts run through the right-shifting stages on a mirrored word.
    assign src = left_kind(kind) ? rev_in : value_in;

    always_comb begin
        unique case (kind)
            SH_ASR:  ext = {DATA_W{src[DATA_W-1]}};
            SH_ROR:  ext = src;
            default: ext = '0;
        endcase
    end

    // The guard bit below the word collects the last bit shifted out.
    assign wide_in = {ext, src, 1'b0};

    shift_log_stages #(.VEC_W(VEC_W), .CNT_W(CNT_W)) i_stages (
        .din   (wide_in),
        .count (count),
        .dout  (wide_out)
    );

    assign body       = wide_out[DATA_W:1];
    assign core_carry = wide_out[0];

    bit_reverse #(.W(DATA_W)) i_rev_out (
        .din  (body),
        .dout (rev_body)
    );

    assign core_value = left_kind(kind) ? rev_body : body;

    always_comb begin
        unique case (ctrl.op)
            OP_PASS: begin
                value_out = value_in;
                carry_out = carry_in;
            end
            OP_RRX: begin
                value_out = {carry_in, value_in[DATA_W-1:1]};
                carry_out = value_in[0];
            end
            OP_CLEAR: begin
                value_out = '0;
                carry_out = 1'b0;
            end
            default: begin
                value_out = core_value;
                carry_out = core_carry;
            end
        endcase
    end

endmodule

// File: rtl/barrel_shift_carry_chk.sv
module barrel_shift_carry_chk #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input logic [1:0]        shift_kind,
    input logic [AMT_W-1:0]  shift_amount,
    input logic              amount_is_imm,
    input logic [DATA_W-1:0] value_in,
    input logic              carry_in,
    input logic [DATA_W-1:0] value_out,
    input logic              carry_out
);
    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

    always_comb begin
        if (!amount_is_imm && shift_amount == '0) begin
            p_reg_zero_pass_r6: assert (value_out == value_in && carry_out == carry_in)
                else $error("R6 register zero amount altered data");
        end
        if (amount_is_imm && shift_amount == '0 && shift_kind == 2'd0) begin
            p_imm_zero_lsl_r7: assert (value_out == value_in && carry_out == carry_in)
                else $error("R7 immediate zero left shift altered data");
        end
        if (amount_is_imm && shift_amount == '0 && shift_kind == 2'd1) begin
            p_imm_zero_lsr_r8: assert (value_out == '0 && carry_out == value_in[DATA_W-1])
                else $error("R8 immediate zero right shift not a full shift");
        end
        if (amount_is_imm && shift_amount == '0 && shift_kind == 2'd3) begin
            p_rrx_r9: assert (value_out == {carry_in, value_in[DATA_W-1:1]}
                              && carry_out == value_in[0])
                else $error("R9 rotate through carry wrong");
        end
        if (shift_kind == 2'd0 && shift_amount > FULL_AMT) begin
            p_lsl_clear_r2: assert (value_out == '0 && !carry_out)
                else $error("R2 oversize left shift not cleared");
        end
        if (shift_kind == 2'd2 && shift_amount >= FULL_AMT) begin
            p_asr_sign_r4: assert (value_out == {DATA_W{value_in[DATA_W-1]}}
                                   && carry_out == value_in[DATA_W-1])
                else $error("R4 wide arithmetic shift wrong");
        end
    end

endmodule

bind barrel_shift_carry barrel_shift_carry_chk #(
    .DATA_W (DATA_W),
    .AMT_W  (AMT_W)
) i_chk (
    .shift_kind    (shift_kind),
    .shift_amount  (shift_amount),
    .amount_is_imm (amount_is_imm),
    .value_in      (value_in),
    .carry_in      (carry_in),
    .value_out     (value_out),
    .carry_out     (carry_out)
);

// File: tb/test_barrel_shift_carry.sv
module test_barrel_shift_carry;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  shift_kind = '0;
    logic [7:0]  shift_amount = '0;
    logic        amount_is_imm = 1'b0;
    logic [31:0] value_in = '0;
    logic        carry_in = 1'b0;
    logic [31:0] value_out;
    logic        carry_out;

    int compared = 0;
    int mismatched = 0;
    logic [31:0] seed = 32'h1357_9BDF;

    always #(CLK_PERIOD / 2) clk = ~clk;

    barrel_shift_carry i_barrel_shift_carry (
        .shift_kind    (shift_kind),
        .shift_amount  (shift_amount),
        .amount_is_imm (amount_is_imm),
        .value_in      (value_in),
        .carry_in      (carry_in),
        .value_out     (value_out),
        .carry_out     (carry_out)
    );

    // Behavioural reference: returns {carry, value}.
    function automatic logic [32:0] model(int kind, logic [31:0] v, int amt, bit imm, bit cin);
        int n;
        int m;
        logic [63:0] t;
        logic [31:0] r;
        n = amt;
        if (amt == 0) begin
            if (!imm || kind == 0) return {cin, v};
            if (kind == 3) return {v[0], cin, v[31:1]};
            n = 32;
        end
        case (kind)
            0: begin
                if (n > 32) return 33'd0;
                t = {32'd0, v} << n;
                return {v[32-n], t[31:0]};
            end
            1: begin
                if (n > 32) return 33'd0;
                t = {v, 32'd0} >> n;
                return {v[n-1], t[63:32]};
            end
            2: begin
                if (n >= 32) return {v[31], {32{v[31]}}};
                r = $signed(v) >>> n;
                return {v[n-1], r};
            end
            default: begin
                m = n % 32;
                if (m == 0) return {v[31], v};
                r = (v >> m) | (v << (32 - m));
                return {v[m-1], r};
            end
        endcase
    endfunction

    function automatic string tag_of(int kind, int amt, bit imm);
        if (amt == 0) begin
            if (!imm) return "R6";
            if (kind == 0) return "R7";
            if (kind == 3) return "R9";
            return "R8";
        end
        if (imm) return "R10";
        case (kind)
            0: return (amt > 32) ? "R2" : "R1";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(int kind, logic [31:0] v, int amt, bit imm, bit cin, string tag);
        logic [32:0] exp;
        @(posedge clk);
        shift_kind    = kind[1:0];
        shift_amount  = amt[7:0];
        amount_is_imm = imm;
        value_in      = v;
        carry_in      = cin;
        exp = model(kind, v, amt, imm, cin);
        @(negedge clk);
        compared++;
        if ({carry_out, value_out} !== exp) begin
            mismatched++;
            $display("FAIL %s kind=%0d val=%h amt=%0d imm=%0b cin=%0b got %h/%0b expected %h/%0b",
                     tag, kind, v, amt, imm, cin, value_out, carry_out, exp[31:0], exp[32]);
        end
    endtask

    task automatic next_seed();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
    endtask

    initial begin
        repeat (CLK_PERIOD * 200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [31:0] words [0:5];
        words[0] = 32'h8000_0000; words[1] = 32'h0000_4001; words[2] = 32'h123F_ABCE;
        words[3] = 32'hA5F9_6342; words[4] = 32'h7FFF_FFFF; words[5] = 32'hFFFF_0000;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Idle state after reset: zero inputs give zero outputs (R6)
        check(0, 32'h0, 0, 1'b0, 1'b0, "R6");
        // Directed corner cases
        check(0, 32'h8000_0000, 1, 1'b0, 1'b0, "R1");
        check(0, 32'h0000_4001, 17, 1'b0, 1'b1, "R1");
        check(0, 32'h0000_4001, 18, 1'b0, 1'b0, "R1");
        check(0, 32'hFFFF_FFFF, 33, 1'b0, 1'b1, "R2");
        check(1, 32'hFFFF_FFFF, 32, 1'b0, 1'b0, "R3");
        check(1, 32'hFFFF_FFFF, 33, 1'b0, 1'b1, "R3");
        check(2, 32'h8000_0000, 32, 1'b0, 1'b0, "R4");
        check(2, 32'hFFC0_0000, 23, 1'b0, 1'b0, "R4");
        check(3, 32'hA5F9_6342, 17, 1'b0, 1'b0, "R5");
        check(3, 32'hFECD_BA12, 32, 1'b0, 1'b0, "R5");
        check(3, 32'hA5F9_6342, 49, 1'b0, 1'b0, "R5");
        check(3, 32'h385F_7DCE, 64, 1'b0, 1'b1, "R5");
        check(2, 32'h1234_5678, 0, 1'b0, 1'b1, "R6");
        check(0, 32'h1234_5678, 0, 1'b1, 1'b1, "R7");
        check(1, 32'hFFFF_FFFF, 0, 1'b1, 1'b0, "R8");
        check(2, 32'h8000_0000, 0, 1'b1, 1'b0, "R8");
        check(3, 32'h123F_ABCE, 0, 1'b1, 1'b1, "R9");
        check(3, 32'h123F_ABCF, 0, 1'b1, 1'b0, "R9");
        check(3, 32'hABCD_1234, 4, 1'b1, 1'b1, "R10");
        // Sweep of kinds, sources, carries and amounts
        for (int w = 0; w < 12; w++) begin
            logic [31:0] v;
            if (w < 6) v = words[w];
            else begin
                next_seed();
                v = seed;
            end
            for (int k = 0; k < 4; k++) begin
                for (int imm = 0; imm < 2; imm++) begin
                    for (int a = 0; a < 44; a++) begin
                        int amt;
                        bit cin;
                        amt = (a < 41) ? a : ((a == 41) ? 64 : ((a == 42) ? 96 : 255));
                        cin = bit'((a + w + k) % 2);
                        check(k, v, amt, bit'(imm), cin, tag_of(k, amt, bit'(imm)));
                    end
                end
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule